// File: doc/BRIEF.md
# Program Trace Sync Request Generator

This block decides whether the next branch message of a program trace stream carries a full address (a sync message) or only a compressed form. It watches a set of event strobes: trace enable, exits from low power and debug states, queue overrun, an external event pin, and messages lost to secure-memory or collision drops. It also runs two saturating counters: compressed branch messages since the last sync, and retired instructions since the last branch. Any of these sets one sticky pending flag. The next branch message that trace emits consumes the flag.

For every branch strobe taken while trace is enabled, the block gives a registered message-kind code one cycle later. The pending flag is also available as a registered output. Message formatting and queueing belong to other blocks.

Top module: `trace_sync_req`

## Requirements
- R1: In the first cycle after synchronous reset is released, `sync_req_o` is 1 and `msg_type_o` is 2'b00.
- R2: When `trace_en_i` goes from 0 to 1, a sync request is raised, so the first branch taken after enabling is a sync message.
- R3: A `lp_exit_i` or `dbg_exit_i` strobe taken while trace is enabled raises a sync request.
- R4: A `q_ovr_i` strobe taken while trace is enabled raises a sync request.
- R5: A rising edge of `evt_pin_i` raises a sync request only when `evt_pin_en_i` is 1 in that cycle. With the enable at 0, the edge has no effect on `sync_req_o` or on the next branch's message kind.
- R6: A `lost_secure_i` or `lost_collide_i` strobe taken while trace is enabled raises a sync request.
- R7: After PER_LIM compressed branch messages in a row with no sync between them, the next branch message is a sync message. A sync message restarts that count.
- R8: Retire strobes in cycles without a branch are counted, and the count saturates at SEQ_LIM. A branch taken while the count is at SEQ_LIM is a sync message. Every emitted branch resets the count. A retire strobe in the same cycle as a branch is not counted.
- R9: One cycle after an emitted branch, `msg_type_o` is 2'b10 for sync or 2'b01 for compressed. It is 2'b00 after any cycle with no emitted branch. After any emitted branch, `sync_req_o` is 0.
- R10: While `trace_en_i` is 0, branch strobes produce 2'b00, event strobes raise no request, and neither counter advances.
- R11: A trigger in the same cycle as a branch makes that branch a sync message, and it leaves no request pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en_i | input | 1 | Program trace enable (level) |
| branch_i | input | 1 | Direct/indirect branch message strobe |
| retire_i | input | 1 | Sequential instruction retired strobe |
| lp_exit_i | input | 1 | Left CPU low power state strobe |
| dbg_exit_i | input | 1 | Left debug mode strobe |
| q_ovr_i | input | 1 | Trace queue overrun strobe |
| evt_pin_i | input | 1 | External event pin, synchronized level |
| evt_pin_en_i | input | 1 | Allows event pin edges to request sync |
| lost_secure_i | input | 1 | Branch message dropped for secure access |
| lost_collide_i | input | 1 | Branch message dropped by a queue collision |
| sync_req_o | output | 1 | Registered sticky sync request |
| msg_type_o | output | 2 | Registered kind of the last-cycle branch: 00 none, 01 compressed, 10 sync |

## Verification
A stuck or lost pending flag appears as a wrong `msg_type_o` on the first branch after a trigger, one cycle after that branch strobe. `sync_req_o` shows the same fault one cycle after the trigger. An off-by-one in either counter shows up only at the branch that should reach the limit, so the bench sweeps the retire count across the limit and runs the periodic count through several wraps. The bench compares both outputs against an independent cycle model after every clock.

// File: rtl/trace_sync_pkg.sv
package trace_sync_pkg;
  typedef enum logic [1:0] {
    MSG_NONE  = 2'b00,
    MSG_PLAIN = 2'b01,
    MSG_SYNC  = 2'b10
  } msg_kind_e;

  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/tsr_edge.sv
module tsr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/tsr_sat_cnt.sv
module tsr_sat_cnt #(
  parameter int LIM = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  import trace_sync_pkg::*;
  localparam int W = cnt_width(LIM);
  localparam logic [W-1:0] LIM_V = W'(LIM);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == LIM_V);

  assert_sat_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_V) else $error("counter above limit");

  assert_sat_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !hit_o || (LIM == 0)) else $error("counter not cleared");
endmodule

// File: rtl/trace_sync_req.sv
module trace_sync_req #(
  parameter int PER_LIM = 255,
  parameter int SEQ_LIM = 255
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trace_en_i,
  input  logic       branch_i,
  input  logic       retire_i,
  input  logic       lp_exit_i,
  input  logic       dbg_exit_i,
  input  logic       q_ovr_i,
  input  logic       evt_pin_i,
  input  logic       evt_pin_en_i,
  input  logic       lost_secure_i,
  input  logic       lost_collide_i,
  output logic       sync_req_o,
  output logic [1:0] msg_type_o
);
  import trace_sync_pkg::*;

  localparam int NEDGE = 2;
  localparam int NSRC  = 9;

  logic [NEDGE-1:0] lvl, rise;
  logic [NSRC-1:0]  src;
  logic             en_rise, evt_rise;
  logic             per_hit, seq_hit;
  logic             trig, need, br_act;
  logic             pend_q;
  msg_kind_e        msg_q;

  assign lvl = {evt_pin_i, trace_en_i};

  tsr_edge #(.N(NEDGE)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (lvl),
    .rise_o(rise)
  );

  assign en_rise  = rise[0];
  assign evt_rise = rise[1] & evt_pin_en_i;

  assign src = {en_rise, lp_exit_i, dbg_exit_i, q_ovr_i, evt_rise,
                lost_secure_i, lost_collide_i, per_hit, seq_hit};

  assign trig   = trace_en_i & (|src);
  assign br_act = branch_i & trace_en_i;
  assign need   = pend_q | trig;

  tsr_sat_cnt #(.LIM(PER_LIM)) u_per_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr_i(br_act & need),
    .inc_i(br_act & ~need),
    .hit_o(per_hit)
  );

  tsr_sat_cnt #(.LIM(SEQ_LIM)) u_seq_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr_i(br_act),
    .inc_i(retire_i & trace_en_i & ~br_act),
    .hit_o(seq_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b1;
      msg_q  <= MSG_NONE;
    end else begin
      if (br_act)    pend_q <= 1'b0;
      else if (trig) pend_q <= 1'b1;
      if (!br_act)   msg_q <= MSG_NONE;
      else if (need) msg_q <= MSG_SYNC;
      else           msg_q <= MSG_PLAIN;
    end
  end

  assign sync_req_o = pend_q;
  assign msg_type_o = msg_q;

  assert_branch_consumes_R9: assert property (@(posedge clk) disable iff (rst)
    (branch_i && trace_en_i) |=> !sync_req_o) else $error("pending not consumed");

  assert_idle_kind_R9: assert property (@(posedge clk) disable iff (rst)
    !(branch_i && trace_en_i) |=> msg_type_o == 2'b00) else $error("kind without branch");

  assert_pending_sync_R11: assert property (@(posedge clk) disable iff (rst)
    (branch_i && trace_en_i && sync_req_o) |=> msg_type_o == 2'b10) else $error("pending ignored");

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!trace_en_i && !sync_req_o) |=> !sync_req_o) else $error("request while disabled");

  assert_enable_sets_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(trace_en_i) && !branch_i) |=> sync_req_o) else $error("enable no request");

  assert_ovr_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (q_ovr_i && trace_en_i && !branch_i) |=> sync_req_o) else $error("overrun no request");
endmodule

// File: tb/trace_sync_req_bench.sv
module trace_sync_req_bench;
  localparam int PER = 5;
  localparam int SEQ = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, br = 1'b0, ret = 1'b0;
  logic lp = 1'b0, dbg = 1'b0, ovr = 1'b0, evt = 1'b0, evt_en = 1'b0;
  logic lsec = 1'b0, lcol = 1'b0;
  logic       sync_req;
  logic [1:0] msg_type;

  int n_chk = 0, n_bad = 0, cycles = 0;
  string tag = "R1";

  // independent cycle model built from the requirements
  bit m_pend = 1'b1;
  int m_pc = 0, m_sc = 0;
  bit m_en_prev = 1'b0, m_evt_prev = 1'b0;
  logic [1:0] m_type = 2'b00;

  always #2 clk = ~clk;

  trace_sync_req #(.PER_LIM(PER), .SEQ_LIM(SEQ)) u_trace_sync_req (
    .clk(clk), .rst(rst), .trace_en_i(en), .branch_i(br), .retire_i(ret),
    .lp_exit_i(lp), .dbg_exit_i(dbg), .q_ovr_i(ovr), .evt_pin_i(evt),
    .evt_pin_en_i(evt_en), .lost_secure_i(lsec), .lost_collide_i(lcol),
    .sync_req_o(sync_req), .msg_type_o(msg_type)
  );

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      report();
      $finish;
    end
  end

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step;
    bit trig, need, bract;
    trig = en && ((en && !m_en_prev) || lp || dbg || ovr || (evt && !m_evt_prev && evt_en)
                  || lsec || lcol || m_pc == PER || m_sc == SEQ);
    need  = m_pend || trig;
    bract = br && en;
    m_type = bract ? (need ? 2'b10 : 2'b01) : 2'b00;
    if (bract) begin
      m_sc = 0;
      if (need) m_pc = 0;
      else if (m_pc < PER) m_pc++;
    end else if (ret && en && m_sc < SEQ) m_sc++;
    m_pend = bract ? 1'b0 : (trig ? 1'b1 : m_pend);
    m_en_prev  = en;
    m_evt_prev = evt;
  endtask

  // ev bits: 0 lp, 1 dbg, 2 ovr, 3 evt pin high, 4 lost secure, 5 lost collide
  task automatic cyc(input logic b, input logic r, input logic [5:0] ev);
    br = b; ret = r;
    lp = ev[0]; dbg = ev[1]; ovr = ev[2]; evt = ev[3]; lsec = ev[4]; lcol = ev[5];
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(msg_type, m_type, "msg_type");
    check({1'b0, sync_req}, {1'b0, m_pend}, "sync_req");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    check(msg_type, 2'b00, "reset kind");
    check({1'b0, sync_req}, 2'b01, "reset request");
    m_en_prev = 1'b0; m_evt_prev = 1'b0;
    model_step();

    tag = "R10";
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 6'(1 << i));
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 6'd0);

    tag = "R2";
    en = 1'b1;
    cyc(1'b1, 1'b0, 6'd0);
    cyc(1'b1, 1'b0, 6'd0);

    for (int s = 0; s < 6; s++) begin
      case (s)
        0, 1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5";
        default: tag = "R6";
      endcase
      evt_en = (s == 3);
      cyc(1'b1, 1'b0, 6'd0);
      cyc(1'b0, 1'b0, 6'(1 << s));
      cyc(1'b0, 1'b0, 6'd0);
      cyc(1'b1, 1'b0, 6'd0);
      cyc(1'b1, 1'b0, 6'd0);
    end

    tag = "R5";
    evt_en = 1'b0;
    cyc(1'b0, 1'b0, 6'b001000);
    cyc(1'b0, 1'b0, 6'd0);
    cyc(1'b1, 1'b0, 6'd0);
    evt_en = 1'b1;
    cyc(1'b0, 1'b0, 6'b001000);
    cyc(1'b1, 1'b0, 6'b001000);
    cyc(1'b1, 1'b0, 6'd0);

    tag = "R11";
    for (int s = 0; s < 6; s++) begin
      cyc(1'b1, 1'b0, 6'(1 << s));
      cyc(1'b1, 1'b0, 6'd0);
    end

    tag = "R7";
    for (int i = 0; i < 3 * (PER + 1) + 2; i++) cyc(1'b1, 1'b0, 6'd0);

    tag = "R8";
    for (int n = 0; n <= SEQ + 2; n++) begin
      cyc(1'b1, 1'b0, 6'd0);
      for (int k = 0; k < n; k++) cyc(1'b0, 1'b1, 6'd0);
      cyc(1'b1, 1'b1, 6'd0);
    end
    for (int i = 0; i < 2 * SEQ + 2; i++) cyc(1'b1, 1'b1, 6'd0);

    tag = "R9";
    for (int i = 0; i < 16; i++) cyc(1'(i % 3 == 0), 1'(i % 2), 6'd0);

    tag = "R10";
    en = 1'b0;
    cyc(1'b0, 1'b0, 6'd0);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 6'(1 << i));
    tag = "R2";
    en = 1'b1;
    cyc(1'b0, 1'b0, 6'd0);
    cyc(1'b1, 1'b0, 6'd0);
    cyc(1'b1, 1'b0, 6'd0);

    report();
    $finish;
  end
endmodule